// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block supplies the address for a four-beat burst into a synchronous memory. When a burst starts, it captures an 18-bit external address. It then produces the remaining beats by stepping only the two lowest address bits. The sixteen upper bits stay at their captured value until the next load.

A one-bit ordering select is captured together with the address at each load. It chooses one of two beat orders. In the linear order, the low bits count upward modulo four from the loaded value. In the interleaved order, the low bits are the loaded low bits XORed with the beat index.

The load strobe arrives already qualified: an address status request together with chip enable. A separate advance input moves the burst to its next beat. When the advance input is low, the burst is suspended. A load that arrives in the middle of a burst restarts the sequence from the new address. All control pins are plain levels sampled on the rising clock edge. There is no handshake and no back-pressure, because every cycle yields exactly one address.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets cur_addr to zero from the following cycle.
- R2: With load high at a rising edge, cur_addr equals the ext_addr sampled at that edge from the next cycle.
- R3: When order_sel was 0 at the load (linear), after k advances the low two bits of cur_addr equal (loaded low bits + k) modulo 4.
- R4: When order_sel was 1 at the load (interleaved), after k advances the low two bits of cur_addr equal the loaded low bits XOR (k modulo 4).
- R5: With load low and advance low at a rising edge, cur_addr keeps its value.
- R6: The fourth advance after a load returns cur_addr to the loaded address, wrapping within the same group of four.
- R7: Bits 17 down to 2 of cur_addr change only at a load or a reset, never at an advance.
- R8: Load takes priority over advance at the same edge and restarts the burst at beat zero with the new address.
- R9: order_sel is sampled only at a load. A change of order_sel while no load is present does not change the ordering of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start a burst at ext_addr (qualified address status), active high |
| advance | input | 1 | Step to the next beat when no load is present, active high |
| order_sel | input | 1 | Beat order taken at load: 0 linear, 1 interleaved |
| ext_addr | input | 18 | External start address |
| cur_addr | output | 18 | Current burst address |

## Verification
On every cycle, the embedded assertions check several behaviours: the reset value, that a load captures ext_addr, that the address holds when the burst is suspended, that the upper bits stay frozen, and that the beat counter steps by one and wraps. Only the bench's scenarios can show the full beat sequences of both orderings against a reference model. The same holds for the wrap back to the start address, a restart that collides with an advance, and the ordering select being ignored in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_step_counter.sv
module burst_step_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (rst || clear) beat <= '0;
    else if (step)    beat <= beat + 1'b1;
  end

  // R6: the beat index advances by one and wraps naturally at the group size
  assert_beat_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!clear && step) |=> beat == BEAT_W'($past(beat) + 1'b1));
  // R8: a clear restarts the beat index at zero
  assert_beat_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> beat == '0);
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  order_e            order_in,
  output logic [ADDR_W-1:0] base,
  output order_e            order_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      order_q <= ORDER_XOR;
    end else if (capture) begin
      base    <= addr_in;
      order_q <= order_in;
    end
  end

  // R2: a load captures the external address
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    capture |=> base == $past(addr_in));
  // R9: the ordering select is retained between loads
  assert_order_held_R9: assert property (@(posedge clk) disable iff (rst)
    !capture |=> order_q == $past(order_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lo_out
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = start_lo + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor_bit
    assign xor_lo[i] = start_lo[i] ^ beat[i];
  end

  always_comb begin
    lo_out = (order == ORDER_XOR) ? xor_lo : lin_lo;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  order_e            order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo_bits;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .capture  (load),
    .addr_in  (ext_addr),
    .order_in (order_e'(order_sel)),
    .base     (base),
    .order_q  (order_q)
  );

  burst_step_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .step  (advance),
    .beat  (beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order    (order_q),
    .start_lo (base[BEAT_W-1:0]),
    .beat     (beat),
    .lo_out   (lo_bits)
  );

  assign cur_addr = {base[ADDR_W-1:BEAT_W], lo_bits};

  // R1: reset clears the address
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> cur_addr == '0);
  // R2: the loaded address appears unchanged on the next cycle
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> cur_addr == $past(ext_addr));
  // R5: suspend keeps the address
  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(cur_addr));
  // R7: upper bits are frozen between loads
  assert_upper_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));
  initial assert (UPPER_W > 0);
endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        load = 1'b0;
  logic        advance = 1'b0;
  logic        order_sel = 1'b0;
  logic [17:0] ext_addr = '0;
  logic [17:0] cur_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  logic [17:0] m_base = '0;
  logic [1:0]  m_k = '0;
  logic        m_xor = 1'b1;

  always #2.5 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr)
  );

  function automatic logic [17:0] model_addr();
    logic [1:0] lo;
    lo = m_xor ? (m_base[1:0] ^ m_k) : 2'(m_base[1:0] + m_k);
    return {m_base[17:2], lo};
  endfunction

  task automatic drive(input logic r, input logic ld, input logic st,
                       input logic md, input logic [17:0] a, input string tag);
    @(negedge clk);
    rst = r; load = ld; advance = st; order_sel = md; ext_addr = a;
    if (r) begin
      m_base = '0; m_k = '0; m_xor = 1'b1;
    end else if (ld) begin
      m_base = a; m_k = '0; m_xor = md;
    end else if (st) begin
      m_k = m_k + 2'd1;
    end
    exp_q.push_back(model_addr());
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (cur_addr !== e) begin
          failures++;
          $display("FAIL %s: cur_addr=%05h expected=%05h", t, cur_addr, e);
        end
      end
    end
  end

  initial begin : stimulus
    drive(1, 0, 0, 0, 18'h3FFFF, "R1");
    drive(1, 0, 0, 0, 18'h0, "R1");
    // linear burst from low bits 01
    drive(0, 1, 0, 0, 18'h2A5C1, "R2");
    drive(0, 0, 1, 0, 18'h0, "R3");
    drive(0, 0, 1, 0, 18'h0, "R3");
    drive(0, 0, 1, 0, 18'h0, "R3");
    drive(0, 0, 1, 0, 18'h0, "R6");
    drive(0, 0, 0, 0, 18'h15555, "R5");
    drive(0, 0, 0, 1, 18'h15555, "R5");
    // interleaved burst from low bits 10
    drive(0, 1, 0, 1, 18'h1F00E, "R2");
    drive(0, 0, 1, 0, 18'h0, "R4");
    drive(0, 0, 0, 0, 18'h0, "R5");
    drive(0, 0, 1, 0, 18'h3FFFF, "R4");
    drive(0, 0, 1, 0, 18'h0, "R7");
    drive(0, 0, 1, 0, 18'h0, "R6");
    // interleaved from 11
    drive(0, 1, 1, 1, 18'h00003, "R8");
    drive(0, 0, 1, 1, 18'h0, "R4");
    drive(0, 0, 1, 1, 18'h0, "R4");
    drive(0, 0, 1, 1, 18'h0, "R4");
    // linear from 11 with order_sel flipped mid-burst
    drive(0, 1, 0, 0, 18'h2FFFF, "R2");
    drive(0, 0, 1, 1, 18'h0, "R9");
    drive(0, 0, 1, 1, 18'h0, "R9");
    drive(0, 0, 1, 1, 18'h0, "R7");
    // restart in the middle of a burst with advance high
    drive(0, 1, 1, 0, 18'h12342, "R8");
    drive(0, 0, 1, 0, 18'h0, "R3");
    drive(0, 1, 1, 1, 18'h0ABC1, "R8");
    drive(0, 0, 1, 0, 18'h0, "R4");
    // reset in the middle of a burst
    drive(1, 0, 1, 0, 18'h0, "R1");
    drive(0, 0, 1, 0, 18'h0, "R4");
    drive(0, 0, 0, 0, 18'h0, "R5");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule